// File: doc/BRIEF.md
# Flash Self-Programming Sequencer

This block lets software running on the CPU reprogram an on-chip program flash model. The model holds 128 pages of 32 sixteen-bit words. Software loads a command into a small control register with one enable bit and three action bits, then issues a trigger strobe. The block can load one word into a temporary page buffer, erase a page, program a page from the buffer, or release the lockout of the read-while-write (RWW) region. Erase and program take a fixed number of clock cycles, set by a parameter. A full-size value models about 4 ms, and a bench can use a small value.

A 16-bit byte pointer selects the target. Bit 0 and bits [15:13] play no part. Bits [5:1] pick the buffer slot and bits [12:6] pick the page. The enable bit serves as the busy flag that software polls: it stays set while an operation runs and clears itself when the operation ends. After an erase or program, the lower part of the flash (word addresses below 0xC00) stays locked until software issues a release command. While it is locked, CPU reads there return all ones and flag a violation. The upper part (0xC00 to 0xFFF) can always be read.

Top module: `selfprog_ctrl`

## Requirements
- R1: A fill command (enable set, no action bit) stores {wdata_hi, wdata_lo} in buffer slot zptr[5:1] at the trigger edge and completes at once.
- R2: An erase command (enable plus erase) sets all 32 words of page zptr[12:6] to 0xFFFF when its timed run ends.
- R3: A program command (enable plus write) copies the 32-word buffer into page zptr[12:6] when its timed run ends, then sets every buffer slot back to 0xFFFF.
- R4: For erase and program, spm_busy stays high for exactly PROG_CYCLES clock edges after the trigger edge and then clears. A control write made while a run is in progress is ignored.
- R5: rww_locked rises when an erase or program starts and stays high until a release command (enable plus rww-release) is accepted.
- R6: zptr bit 0 and bits [15:13] have no effect on any command.
- R7: A program command with a nonzero zptr[5:1] causes no flash or buffer change. It clears spm_busy and gives a one-cycle prog_err pulse in the cycle after the trigger edge.
- R8: A trigger that arrives while ee_busy is high is dropped: no effect, and spm_busy clears.
- R9: A trigger counts only if it arrives 1 to 4 cycles after the control write. Later, the register clears itself with no effect.
- R10: Reads have one cycle of latency. While rww_locked is high, a read below word 0xC00 returns 0xFFFF with a one-cycle rd_viol pulse, and reads at 0xC00 and above return stored data.
- R11: A trigger while the enable bit is clear does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable bit written with ctl_wr |
| ctl_erase | input | 1 | Erase action bit |
| ctl_write | input | 1 | Program action bit |
| ctl_rwwen | input | 1 | RWW release action bit |
| spm_go | input | 1 | Command trigger strobe |
| zptr | input | 16 | Byte pointer (word [5:1], page [12:6]) |
| wdata_lo | input | 8 | Low byte of the fill word |
| wdata_hi | input | 8 | High byte of the fill word |
| ee_busy | input | 1 | EEPROM write pending |
| rd_en | input | 1 | CPU flash read strobe |
| rd_addr | input | 12 | CPU read word address |
| rd_data | output | 16 | Read data, one cycle after rd_en |
| rd_viol | output | 1 | Pulse for a blocked read of the locked region |
| spm_busy | output | 1 | Enable bit; high until the command completes |
| rww_locked | output | 1 | RWW region unreadable |
| prog_err | output | 1 | Pulse: program issued with nonzero word field |

## Verification
The page program path is driven with random data in every buffer slot and with random junk in the ignored pointer bits. Some programs follow a full buffer, some a partly filled one and some an empty one. Comparing these shows whether the buffer clears after a program and whether the pointer decode ignores the right bits. Directed cases place the trigger at the last accepted gap and at the first rejected gap, and also raise the EEPROM-busy input, enter a nonzero word field and clear the enable bit. Each of these must leave the page unchanged, which separates a rejected command from an accepted one. Reads on both sides of the 0xC00 boundary, made during lockout, separate gated data from stored data.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    typedef enum logic [2:0] {
        CMD_FILL,
        CMD_ERASE,
        CMD_WRITE,
        CMD_RWWEN,
        CMD_BAD
    } cmd_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    typedef struct packed {
        logic en;
        logic erase;
        logic write;
        logic rwwen;
    } ctl_s;

    localparam logic [15:0] ERASED_WORD = 16'hFFFF;

    function automatic cmd_e classify(input ctl_s c);
        cmd_e r;
        case ({c.erase, c.write, c.rwwen})
            3'b000:  r = CMD_FILL;
            3'b100:  r = CMD_ERASE;
            3'b010:  r = CMD_WRITE;
            3'b001:  r = CMD_RWWEN;
            default: r = CMD_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
    import selfprog_pkg::*;
#(
    parameter int WINDOW    = 4,
    parameter int WORD_BITS = 5,
    parameter int PAGE_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_wr,
    input  ctl_s                 ctl_in,
    input  logic                 go,
    input  logic                 ee_busy,
    input  logic [15:0]          zptr,
    input  logic                 eng_idle,
    input  logic                 eng_done,
    output logic                 en_flag,
    output logic                 win_open,
    output logic                 accept,
    output logic                 start_fill,
    output logic                 start_erase,
    output logic                 start_write,
    output logic                 rww_clear,
    output logic                 err_q,
    output logic [WORD_BITS-1:0] word_sel,
    output logic [PAGE_BITS-1:0] page_sel
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    ctl_s             ctl_q;
    logic [WIN_W-1:0] win_cnt;
    cmd_e             cmd;
    logic             trig;
    logic             bad_write;
    logic             unused_ptr_bits;

    assign word_sel        = zptr[WORD_BITS:1];
    assign page_sel        = zptr[WORD_BITS+PAGE_BITS:WORD_BITS+1];
    assign unused_ptr_bits = ^{zptr[15:WORD_BITS+PAGE_BITS+1], zptr[0]};

    assign cmd         = classify(ctl_q);
    assign win_open    = (win_cnt != '0);
    assign trig        = go && win_open && eng_idle;
    assign accept      = trig && ctl_q.en && !ee_busy;
    assign start_fill  = accept && (cmd == CMD_FILL);
    assign start_erase = accept && (cmd == CMD_ERASE);
    assign start_write = accept && (cmd == CMD_WRITE) && (word_sel == '0);
    assign bad_write   = accept && (cmd == CMD_WRITE) && (word_sel != '0);
    assign rww_clear   = accept && (cmd == CMD_RWWEN);
    assign en_flag     = ctl_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            win_cnt <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= bad_write;
            if (eng_done) begin
                ctl_q <= '0;
            end else if (ctl_wr && eng_idle) begin
                ctl_q   <= ctl_in;
                win_cnt <= WIN_W'(WINDOW);
            end else if (trig) begin
                win_cnt <= '0;
                if (!(start_erase || start_write)) ctl_q <= '0;
            end else if (win_open) begin
                win_cnt <= win_cnt - 1'b1;
                if (win_cnt == WIN_W'(1)) ctl_q <= '0;
            end
        end
    end

endmodule

// File: rtl/selfprog_engine.sv
module selfprog_engine
    import selfprog_pkg::*;
#(
    parameter int PROG_CYCLES = 32000,
    parameter int PAGE_BITS   = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_erase,
    input  logic                 start_write,
    input  logic                 rww_clear,
    input  logic [PAGE_BITS-1:0] page_in,
    output logic                 idle,
    output logic                 done,
    output logic                 commit_erase,
    output logic                 commit_write,
    output logic [PAGE_BITS-1:0] page_q,
    output logic                 rww_busy
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    eng_state_e    state;
    logic [TW-1:0] timer;
    logic          is_write;

    assign idle         = (state == ENG_IDLE);
    assign done         = (state == ENG_RUN) && (timer == '0);
    assign commit_erase = done && !is_write;
    assign commit_write = done && is_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            timer    <= '0;
            is_write <= 1'b0;
            page_q   <= '0;
            rww_busy <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start_erase || start_write) begin
                        state    <= ENG_RUN;
                        timer    <= TW'(PROG_CYCLES - 1);
                        is_write <= start_write;
                        page_q   <= page_in;
                        rww_busy <= 1'b1;
                    end else if (rww_clear) begin
                        rww_busy <= 1'b0;
                    end
                end
                ENG_RUN: begin
                    if (timer == '0) state <= ENG_IDLE;
                    else             timer <= timer - 1'b1;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/selfprog_array.sv
module selfprog_array
    import selfprog_pkg::*;
#(
    parameter int WORD_BITS = 5,
    parameter int PAGE_BITS = 7,
    parameter int RWW_LIMIT = 3072
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           fill,
    input  logic [WORD_BITS-1:0]           fill_word,
    input  logic [15:0]                    fill_data,
    input  logic                           commit_erase,
    input  logic                           commit_write,
    input  logic [PAGE_BITS-1:0]           page,
    input  logic                           rww_busy,
    input  logic                           rd_en,
    input  logic [PAGE_BITS+WORD_BITS-1:0] rd_addr,
    output logic [15:0]                    rd_data,
    output logic                           rd_viol
);
    localparam int PAGE_WORDS = 1 << WORD_BITS;
    localparam int DEPTH      = PAGE_WORDS << PAGE_BITS;

    logic [15:0] pbuf [PAGE_WORDS];
    logic [15:0] mem  [DEPTH];
    logic        in_rww;

    assign in_rww = (int'(rd_addr) < RWW_LIMIT);

    always_ff @(posedge clk) begin
        if (rst || commit_write) begin
            for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= ERASED_WORD;
        end else if (fill) begin
            pbuf[fill_word] <= fill_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_WORDS; i++) begin
            if (commit_erase) mem[{page, i[WORD_BITS-1:0]}] <= ERASED_WORD;
            else if (commit_write) mem[{page, i[WORD_BITS-1:0]}] <= pbuf[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= ERASED_WORD;
            rd_viol <= 1'b0;
        end else begin
            rd_viol <= rd_en && rww_busy && in_rww;
            if (rd_en) rd_data <= (rww_busy && in_rww) ? ERASED_WORD : mem[rd_addr];
        end
    end

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int PAGE_BITS   = 7,
    parameter int WORD_BITS   = 5,
    parameter int NRWW_PAGES  = 32,
    parameter int PROG_CYCLES = 32000,
    parameter int WINDOW      = 4,
    localparam int ADDR_W     = PAGE_BITS + WORD_BITS,
    localparam int RWW_LIMIT  = ((1 << PAGE_BITS) - NRWW_PAGES) << WORD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic              ctl_erase,
    input  logic              ctl_write,
    input  logic              ctl_rwwen,
    input  logic              spm_go,
    input  logic [15:0]       zptr,
    input  logic [7:0]        wdata_lo,
    input  logic [7:0]        wdata_hi,
    input  logic              ee_busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              rd_viol,
    output logic              spm_busy,
    output logic              rww_locked,
    output logic              prog_err
);
    ctl_s                 ctl_in;
    logic                 eng_idle, eng_done, win_open, accept;
    logic                 start_fill, start_erase, start_write, rww_clear;
    logic                 commit_erase, commit_write;
    logic [WORD_BITS-1:0] word_sel;
    logic [PAGE_BITS-1:0] page_sel, page_q;

    assign ctl_in = '{en: ctl_en, erase: ctl_erase, write: ctl_write, rwwen: ctl_rwwen};

    selfprog_ctl #(
        .WINDOW(WINDOW), .WORD_BITS(WORD_BITS), .PAGE_BITS(PAGE_BITS)
    ) u_ctl (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_in(ctl_in), .go(spm_go),
        .ee_busy(ee_busy), .zptr(zptr), .eng_idle(eng_idle), .eng_done(eng_done),
        .en_flag(spm_busy), .win_open(win_open), .accept(accept),
        .start_fill(start_fill), .start_erase(start_erase), .start_write(start_write),
        .rww_clear(rww_clear), .err_q(prog_err), .word_sel(word_sel), .page_sel(page_sel)
    );

    selfprog_engine #(
        .PROG_CYCLES(PROG_CYCLES), .PAGE_BITS(PAGE_BITS)
    ) u_eng (
        .clk(clk), .rst(rst), .start_erase(start_erase), .start_write(start_write),
        .rww_clear(rww_clear), .page_in(page_sel), .idle(eng_idle), .done(eng_done),
        .commit_erase(commit_erase), .commit_write(commit_write), .page_q(page_q),
        .rww_busy(rww_locked)
    );

    selfprog_array #(
        .WORD_BITS(WORD_BITS), .PAGE_BITS(PAGE_BITS), .RWW_LIMIT(RWW_LIMIT)
    ) u_arr (
        .clk(clk), .rst(rst), .fill(start_fill), .fill_word(word_sel),
        .fill_data({wdata_hi, wdata_lo}), .commit_erase(commit_erase),
        .commit_write(commit_write), .page(page_q), .rww_busy(rww_locked),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_viol(rd_viol)
    );

endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
    parameter int ADDR_W    = 12,
    parameter int RWW_LIMIT = 3072
) (
    input logic              clk,
    input logic              rst,
    input logic              eng_idle,
    input logic              win_open,
    input logic              accept,
    input logic              start_erase,
    input logic              start_write,
    input logic              rww_clear,
    input logic              ee_busy,
    input logic              rww_locked,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [15:0]       rd_data,
    input logic              rd_viol,
    input logic              spm_busy,
    input logic              prog_err
);
    p_busy_flag_r4: assert property (@(posedge clk) disable iff (rst)
        !eng_idle |-> spm_busy);

    p_lock_set_r5: assert property (@(posedge clk) disable iff (rst)
        (start_erase || start_write) |=> rww_locked);

    p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rww_locked && !rww_clear) |=> rww_locked);

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        prog_err |=> !prog_err);

    p_ee_block_r8: assert property (@(posedge clk) disable iff (rst)
        ee_busy |-> !accept);

    p_window_r9: assert property (@(posedge clk) disable iff (rst)
        !win_open |-> !accept);

    p_viol_raise_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rww_locked && (int'(rd_addr) < RWW_LIMIT)) |=> (rd_viol && rd_data == 16'hFFFF));

    p_viol_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_viol);

endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(.ADDR_W(ADDR_W), .RWW_LIMIT(RWW_LIMIT)) u_chk (
    .clk(clk), .rst(rst), .eng_idle(eng_idle), .win_open(win_open), .accept(accept),
    .start_erase(start_erase), .start_write(start_write), .rww_clear(rww_clear),
    .ee_busy(ee_busy), .rww_locked(rww_locked), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_viol(rd_viol), .spm_busy(spm_busy), .prog_err(prog_err)
);

// File: tb/selfprog_ctrl_tb.sv
module selfprog_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 20;

    logic        clk = 1'b0, rst = 1'b1;
    logic        ctl_wr = 0, ctl_en = 0, ctl_erase = 0, ctl_write = 0, ctl_rwwen = 0;
    logic        spm_go = 0, ee_busy = 0, rd_en = 0;
    logic [15:0] zptr = '0;
    logic [7:0]  wdata_lo = '0, wdata_hi = '0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_viol, spm_busy, rww_locked, prog_err;

    int total = 0, bad = 0;
    logic [15:0] mbuf [32];
    logic [15:0] mmem [4096];
    bit          known [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    selfprog_ctrl #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_erase(ctl_erase),
        .ctl_write(ctl_write), .ctl_rwwen(ctl_rwwen), .spm_go(spm_go), .zptr(zptr),
        .wdata_lo(wdata_lo), .wdata_hi(wdata_hi), .ee_busy(ee_busy), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_viol(rd_viol), .spm_busy(spm_busy),
        .rww_locked(rww_locked), .prog_err(prog_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkptr(input int page, input int word);
        return {3'($urandom), page[6:0], word[4:0], 1'($urandom)};
    endfunction

    task automatic issue(input logic en, er, wr, rw, input int page, input int word,
                         input logic [15:0] d, input int gap, input logic ee);
        @(negedge clk);
        ctl_wr = 1; ctl_en = en; ctl_erase = er; ctl_write = wr; ctl_rwwen = rw;
        zptr = mkptr(page, word); {wdata_hi, wdata_lo} = d; ee_busy = ee;
        @(negedge clk);
        ctl_wr = 0;
        repeat (gap - 1) @(negedge clk);
        spm_go = 1;
        @(negedge clk);
        spm_go = 0; ee_busy = 0;
    endtask

    task automatic wait_done(output int n);
        n = spm_busy ? 1 : 0;
        while (spm_busy && n < 1000) begin
            @(negedge clk);
            if (spm_busy) n++;
        end
    endtask

    task automatic rd(input int addr, output logic [15:0] d, output logic v);
        @(negedge clk);
        rd_en = 1; rd_addr = addr[11:0];
        @(negedge clk);
        d = rd_data; v = rd_viol; rd_en = 0;
    endtask

    task automatic fill(input int word, input logic [15:0] d);
        issue(1, 0, 0, 0, 0, word, d, 1 + ($urandom % 4), 0);
        mbuf[word] = d;
    endtask

    task automatic release_rww();
        issue(1, 0, 0, 1, 0, 0, 16'h0, 1, 0);
        chk(rww_locked == 0, "R5 release", rww_locked, 0);
    endtask

    task automatic program_page(input int page);
        int n;
        issue(1, 0, 1, 0, page, 0, 16'h0, 1 + ($urandom % 4), 0);
        wait_done(n);
        chk(n == PROG, "R4 program duration", n, PROG);
        chk(rww_locked == 1, "R5 locked after program", rww_locked, 1);
        for (int i = 0; i < 32; i++) begin
            mmem[page*32+i] = mbuf[i];
            mbuf[i] = 16'hFFFF;
        end
        known[page] = 1;
    endtask

    task automatic erase_page(input int page, input int gap);
        int n;
        issue(1, 1, 0, 0, page, 0, 16'h0, gap, 0);
        wait_done(n);
        chk(n == PROG, "R4 erase duration", n, PROG);
        for (int i = 0; i < 32; i++) mmem[page*32+i] = 16'hFFFF;
        known[page] = 1;
    endtask

    task automatic check_page(input int page, input string req);
        logic [15:0] d;
        logic v;
        for (int i = 0; i < 32; i++) begin
            rd(page*32+i, d, v);
            chk(d == mmem[page*32+i] && v == 0, req, d, mmem[page*32+i]);
        end
    endtask

    initial begin
        logic [15:0] d;
        logic v;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) mbuf[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(spm_busy == 0 && rww_locked == 0 && rd_viol == 0 && prog_err == 0,
            "reset state", {spm_busy, rww_locked, rd_viol, prog_err}, 0);

        // R1 R3 R6: full random buffer into NRWW page 100
        for (int i = 0; i < 32; i++) fill(i, 16'($urandom));
        program_page(100);
        rd(100*32 + 7, d, v);
        chk(d == mmem[100*32+7] && v == 0, "R10 upper region readable while locked", d, mmem[100*32+7]);
        rd(5*32 + 3, d, v);
        chk(d == 16'hFFFF && v == 1, "R10 lower region gated while locked", {v, d}, 32'h1FFFF);
        rd(12'hBFF, d, v);
        chk(v == 1, "R10 last gated word", v, 1);
        release_rww();
        check_page(100, "R1 R3 R6 page contents");

        // R3: buffer cleared after program
        program_page(101);
        release_rww();
        check_page(101, "R3 buffer cleared after program");

        // random mix of partial fills, programs and erases
        for (int k = 0; k < 8; k++) begin
            int page = $urandom % 128;
            if ($urandom % 3 == 0) begin
                erase_page(page, 1 + ($urandom % 4));
            end else begin
                int cnt = 1 + ($urandom % 32);
                for (int j = 0; j < cnt; j++) fill($urandom % 32, 16'($urandom));
                program_page(page);
            end
            release_rww();
            check_page(page, "R1 R2 R3 random page");
        end

        // R2: erase of a programmed page
        erase_page(100, 2);
        release_rww();
        check_page(100, "R2 erase");

        // R7: nonzero word field on program
        for (int i = 0; i < 32; i++) fill(i, 16'(i * 16'h0101 + 16'h1234));
        program_page(40);
        release_rww();
        fill(3, 16'hA5A5);
        issue(1, 0, 1, 0, 40, 5, 16'h0, 1, 0);
        chk(prog_err == 1, "R7 error pulse", prog_err, 1);
        chk(spm_busy == 0 && rww_locked == 0, "R7 rejected", {spm_busy, rww_locked}, 0);
        @(negedge clk);
        chk(prog_err == 0, "R7 pulse one cycle", prog_err, 0);
        check_page(40, "R7 page unchanged");

        // R8: EEPROM busy at trigger
        issue(1, 1, 0, 0, 40, 0, 16'h0, 1, 1);
        chk(spm_busy == 0 && rww_locked == 0, "R8 dropped", {spm_busy, rww_locked}, 0);
        check_page(40, "R8 page unchanged");

        // R9: gap 5 rejected, gap 4 accepted
        issue(1, 1, 0, 0, 40, 0, 16'h0, 5, 0);
        chk(spm_busy == 0 && rww_locked == 0, "R9 late trigger", {spm_busy, rww_locked}, 0);
        check_page(40, "R9 late trigger page unchanged");

        // R11: enable clear
        issue(0, 1, 0, 0, 40, 0, 16'h0, 1, 0);
        chk(spm_busy == 0 && rww_locked == 0, "R11 no enable", {spm_busy, rww_locked}, 0);
        check_page(40, "R11 page unchanged");

        // R4: control write during a run is ignored, R9 gap 4 accepted
        issue(1, 1, 0, 0, 40, 0, 16'h0, 4, 0);
        chk(spm_busy == 1, "R9 gap 4 accepted", spm_busy, 1);
        issue(1, 0, 0, 1, 0, 0, 16'h0, 1, 0);
        wait_done(n);
        chk(rww_locked == 1, "R4 control write ignored while busy", rww_locked, 1);
        for (int i = 0; i < 32; i++) mmem[40*32+i] = 16'hFFFF;
        release_rww();
        check_page(40, "R2 erase after gap 4");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule